// File: doc/BRIEF.md
# Sliding-Window Refresh Slot Enforcer

This block sits between a memory client and a multi-banked dynamic memory whose refresh scheduler needs a minimum number of refresh-capable slots. A slot is refresh-capable ("credited") when it carries no access, when the scheduler reports that the access does not touch the bank it wants to refresh, or when this block forces it idle. Its guarantee is that every run of `WIN` consecutive slots, starting at any cycle, holds at least `NEED` credited slots. It does not split time into fixed frames. Idles can therefore sit anywhere around a burst. The refresh cost is `NEED/WIN` of the slots, and the longest uninterrupted access burst is `WIN-NEED` slots.

Each cycle the client presents `req_valid` and the scheduler presents `no_conflict`. A request that conflicts is held off with `stall` (and `req_ready` low) only when the previous `WIN-1` slots hold fewer than `NEED` credits. The client keeps its request and retries. The block stores the last `WIN-1` credit bits and a running tally of them. A two-state controller, registered from the next tally, decides whether a conflicting access may pass:
- **ST_SLACK**: the previous `WIN-1` slots hold at least `NEED` credits, so every access passes.
- **ST_EDGE**: exactly `NEED-1` credits remain, so a conflicting access is stalled.

The transition SLACK→EDGE happens when the next tally drops below `NEED`. EDGE→SLACK happens when it reaches `NEED` again. Otherwise the state is held. Reset puts the controller in ST_SLACK with the history full of credits. Legal parameters satisfy 1 ≤ `NEED` ≤ `WIN-1`.

Top module: `slot_window_enforcer`

## Requirements
- R1: Reset makes the history count as fully credited, with `stall`=0 and `req_ready`=1. An unbroken conflicting burst started right after reset receives exactly `WIN-NEED` grants before its first stall.
- R2: Every window of `WIN` consecutive slots, at any start position, contains at least `NEED` slots with `slot_credit`=1.
- R3: `stall` is 1 only for a conflicting slot (`req_valid`=1, `no_conflict`=0) whose previous `WIN-1` slots hold fewer than `NEED` credits. In every other case `stall` is 0.
- R4: A slot with `req_valid`=0 is credited and never stalled.
- R5: A slot with `no_conflict`=1 is credited and never stalled, whatever `req_valid` is.
- R6: Under continuous conflicting requests, after the initial grants the outputs repeat with period `WIN`: `NEED` stalled slots followed by `WIN-NEED` granted slots.
- R7: In a stalled slot `req_ready` is 0 and the slot is credited. In an unstalled slot `req_ready` is 1.
- R8: No run of consecutive uncredited slots is longer than `WIN-NEED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one timeslot per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client wants to access memory in this slot |
| no_conflict | input | 1 | Scheduler: this slot's access misses the bank being refreshed |
| req_ready | output | 1 | Access accepted in this slot |
| stall | output | 1 | Access held off to force a refresh slot |
| slot_credit | output | 1 | This slot counts as refresh-capable |

## Verification
The assertions assume that `req_valid` and `no_conflict` are settled before each rising edge. They also assume the client treats a stalled request as not taken and does not read `req_ready` as a grant when `req_valid` is low. They place no constraint on how often or how long the client bursts: any mix of the three slot kinds must keep the window floor. The stimulus changes inputs only on falling edges. It covers every sequence of seven slot kinds back to back, unbroken worst-case conflicting bursts from reset, and random bursty traffic that includes idle slots flagged as no-conflict.

// File: rtl/enf_pkg.sv
`timescale 1ns/1ps
package enf_pkg;
    typedef enum logic {
        ST_SLACK = 1'b0,
        ST_EDGE  = 1'b1
    } enf_state_e;
endpackage

// File: rtl/enf_history.sv
`timescale 1ns/1ps
// Shift store of the last DEPTH credit bits; oldest bit leaves each slot.
module enf_history #(
    parameter int DEPTH = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic credit,
    output logic oldest
);
    logic [DEPTH-1:0] bits_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) bits_q <= '1;
                else        bits_q <= credit;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) bits_q <= '1;
                else        bits_q <= {bits_q[DEPTH-2:0], credit};
            end
        end
    endgenerate

    assign oldest = bits_q[DEPTH-1];
endmodule

// File: rtl/enf_tally.sv
`timescale 1ns/1ps
// Running count of credits held in the history store.
module enf_tally #(
    parameter int DEPTH = 25,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          credit,
    input  logic          oldest,
    output logic [CW-1:0] count_nx
);
    logic [CW-1:0] count_q;

    always_comb begin
        count_nx = count_q + {{(CW-1){1'b0}}, credit} - {{(CW-1){1'b0}}, oldest};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= CW'(DEPTH);
        else        count_q <= count_nx;
    end
endmodule

// File: rtl/enf_fsm.sv
`timescale 1ns/1ps
// Two-state controller: slack in the window or on its last spare credit.
module enf_fsm
    import enf_pkg::*;
#(
    parameter int NEED = 1,
    parameter int CW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conflict,
    input  logic [CW-1:0] count_nx,
    output logic          stall
);
    enf_state_e state_q;
    enf_state_e state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_SLACK: if (count_nx < CW'(NEED))  state_nx = ST_EDGE;
            ST_EDGE:  if (count_nx >= CW'(NEED)) state_nx = ST_SLACK;
            default:  state_nx = ST_SLACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SLACK;
        else        state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_SLACK: stall = 1'b0;
            ST_EDGE:  stall = conflict;
            default:  stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/slot_window_enforcer.sv
`timescale 1ns/1ps
// Guarantees NEED refresh-capable slots in every WIN consecutive slots.
module slot_window_enforcer #(
    parameter int WIN  = 26,
    parameter int NEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic no_conflict,
    output logic req_ready,
    output logic stall,
    output logic slot_credit
);
    localparam int DEPTH = WIN - 1;
    localparam int CW    = $clog2(WIN) + 1;

    logic          conflict;
    logic          oldest;
    logic [CW-1:0] count_nx;

    assign conflict    = req_valid & ~no_conflict;
    assign slot_credit = ~conflict | stall;
    assign req_ready   = ~stall;

    enf_history #(.DEPTH(DEPTH)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .credit (slot_credit),
        .oldest (oldest)
    );

    enf_tally #(.DEPTH(DEPTH), .CW(CW)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .credit   (slot_credit),
        .oldest   (oldest),
        .count_nx (count_nx)
    );

    enf_fsm #(.NEED(NEED), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .conflict (conflict),
        .count_nx (count_nx),
        .stall    (stall)
    );
endmodule

// File: rtl/enf_window_chk.sv
`timescale 1ns/1ps
module enf_window_chk #(
    parameter int WIN  = 26,
    parameter int NEED = 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic no_conflict,
    input logic req_ready,
    input logic stall,
    input logic slot_credit
);
    localparam int RW = $clog2(WIN) + 1;

    logic [WIN-2:0] seen_q;
    logic [RW-1:0]  run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '1;
            run_q  <= '0;
        end else begin
            seen_q <= {seen_q[WIN-3:0], slot_credit};
            run_q  <= slot_credit ? '0 : run_q + 1'b1;
        end
    end

    p_window_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({seen_q, slot_credit}) >= NEED);

    p_stall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (req_valid && !no_conflict && $countones(seen_q) < NEED));

    p_idle_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!stall && slot_credit));

    p_nc_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        no_conflict |-> (!stall && slot_credit));

    p_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!req_ready && slot_credit));

    p_run_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_credit |-> (int'(run_q) < WIN - NEED));
endmodule

bind slot_window_enforcer enf_window_chk #(.WIN(WIN), .NEED(NEED)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .no_conflict (no_conflict),
    .req_ready   (req_ready),
    .stall       (stall),
    .slot_credit (slot_credit)
);

// File: tb/tb_slot_window_enforcer.sv
`timescale 1ns/1ps
module tb_slot_window_enforcer;
    localparam int WIN   = 6;
    localparam int NEED  = 2;
    localparam int DEPTH = WIN - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic no_conflict = 1'b0;
    logic req_ready, stall, slot_credit;

    int n_chk = 0;
    int n_bad = 0;
    logic [DEPTH-1:0] m_hist;
    logic [DEPTH-1:0] o_hist;
    int run_len;

    always #10 clk = ~clk;

    slot_window_enforcer #(.WIN(WIN), .NEED(NEED)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .no_conflict(no_conflict),
        .req_ready(req_ready), .stall(stall), .slot_credit(slot_credit)
    );

    task automatic check1(input string rq, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; no_conflict = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_hist = '1; o_hist = '1; run_len = 0;
        #5;
        check1("R1 reset stall", stall, 1'b0);
        check1("R1 reset ready", req_ready, 1'b1);
        check1("R4 reset credit", slot_credit, 1'b1);
    endtask

    // One slot: drive on the falling edge, compare before the rising edge.
    task automatic step(input logic v, input logic nc, output logic st);
        logic e_st, e_cr;
        if (!clk) @(posedge clk);
        @(negedge clk);
        req_valid = v; no_conflict = nc;
        #5;
        e_st = v && !nc && ($countones(m_hist) < NEED);
        e_cr = !v || nc || e_st;
        check1("R3 stall", stall, e_st);
        check1("R7 ready", req_ready, !e_st);
        if (!v) check1("R4 idle credit", slot_credit, 1'b1);
        else if (nc) check1("R5 nc credit", slot_credit, 1'b1);
        else check1("R7 credit", slot_credit, e_cr);
        n_chk++;
        if ($countones({o_hist, slot_credit}) < NEED) begin
            n_bad++;
            $display("FAIL R2: actual %0d credits expected >= %0d",
                     $countones({o_hist, slot_credit}), NEED);
        end
        run_len = slot_credit ? 0 : run_len + 1;
        n_chk++;
        if (run_len > WIN - NEED) begin
            n_bad++;
            $display("FAIL R8: actual run %0d expected <= %0d", run_len, WIN - NEED);
        end
        m_hist = {m_hist[DEPTH-2:0], e_cr};
        o_hist = {o_hist[DEPTH-2:0], slot_credit};
        st = stall;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic s;
        do_reset();

        // R1 and R6: unbroken worst-case conflicting burst from reset.
        for (int k = 0; k < 4 * WIN; k++) begin
            logic e;
            step(1'b1, 1'b0, s);
            e = (k >= WIN - NEED) && (((k - (WIN - NEED)) % WIN) < NEED);
            if (k == WIN - NEED) check1("R1 first stall", s, 1'b1);
            else check1("R6 period", s, e);
        end

        // R5: no-conflict accesses in a tight window are never held off.
        for (int k = 0; k < 2 * WIN; k++) begin
            step(1'b1, 1'b1, s);
            check1("R5 no stall", s, 1'b0);
        end
        step(1'b0, 1'b1, s);
        check1("R5 idle nc", s, 1'b0);

        // Sweep of all seven-slot sequences of idle / conflict / no-conflict.
        do_reset();
        for (int p = 0; p < 2187; p++) begin
            int code = p;
            for (int d = 0; d < 7; d++) begin
                int dig = code % 3;
                code = code / 3;
                step(dig != 0, dig == 2, s);
            end
        end

        // Random bursty traffic.
        do_reset();
        for (int b = 0; b < 300; b++) begin
            int len = $urandom_range(1, 3 * WIN);
            for (int k = 0; k < len; k++) step(1'b1, ($urandom_range(0, 7) == 0), s);
            for (int k = 0; k < $urandom_range(0, 2); k++)
                step(1'b0, ($urandom_range(0, 1) == 1), s);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule